// File: doc/BRIEF.md
# Transceiver Power-Up Reset Sequencer

This block takes a serial transceiver channel from power-up to a usable link. It runs on the management clock and waits for a qualified management reset. It then releases the channel hold and calibration-start resets together. After that it follows calibration, TX PLL lock and CDR lock progress, and releases the TX and RX analog and PCS resets in a fixed order. When each direction is usable it raises that direction's link-ok status.

Each lock input is brought into the clock domain by a two-flop synchronizer. It then has to stay high for `LOCK_FILT` consecutive clocks before it is treated as locked. If PLL lock or CDR data lock is lost later, the matching PCS reset is asserted again and the matching status is withdrawn. The channel recovers without a new management reset once lock returns.

A management reset that is too short parks the block. All resets stay asserted until a reset of full length arrives. Calibration-busy is ignored on the first clock after the sequence starts, because the calibration engine only raises it from the second clock onward.

Top module: `xcvr_pwrup_rst_seq`

## Requirements
- R1: A sequence starts only on the first clock where `mgmt_rst` is sampled low after being sampled high on at least `RST_MIN_CYC` (default 2) consecutive clocks. A shorter pulse leaves every reset output asserted and both link-ok outputs low until a qualifying reset is seen.
- R2: `xcvr_hold_rst`, `cal_start_rst` and `tx_pma_rst` fall together, on the clock edge that starts the sequence.
- R3: `cal_busy` is ignored on the first clock edge after the start edge. Calibration is complete from the first later edge that samples `cal_busy` low.
- R4: `tx_pcs_rst` is low only while calibration is complete and the filtered TX PLL lock is held. It is updated one clock after either condition changes.
- R5: `tx_link_ok` rises one clock after `tx_pcs_rst` falls. It stays high while `tx_pcs_rst` stays low.
- R6: Each lock input is sampled through two flops and must then be high on `LOCK_FILT` (default 8) consecutive clocks before it counts as locked. A drop clears the count.
- R7: `rx_pma_rst` falls one clock after calibration is complete.
- R8: `rx_pcs_rst` is released only when three things hold: `rx_pma_rst` is low, filtered lock-to-reference has been seen at least once since the start, and filtered lock-to-data is held.
- R9: `rx_link_ok` rises `RX_GUARD` (default 4) clocks after `rx_pcs_rst` falls.
- R10: When filtered PLL lock is lost, `tx_pcs_rst` rises and `tx_link_ok` falls on the same edge. When filtered lock-to-data is lost, `rx_pcs_rst` rises and `rx_link_ok` falls on the same edge.
- R11: On the edge after any clock with `mgmt_rst` high, every reset output is high and both link-ok outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Management clock |
| mgmt_rst | input | 1 | Management reset, active high, sampled synchronously |
| cal_busy | input | 1 | Calibration in progress, from the reconfiguration controller |
| tx_pll_locked | input | 1 | TX PLL lock flag, asynchronous |
| rx_locked_ref | input | 1 | CDR locked to reference clock, asynchronous |
| rx_locked_data | input | 1 | CDR locked to incoming data, asynchronous |
| xcvr_hold_rst | output | 1 | Holds the transceiver blocks in reset |
| cal_start_rst | output | 1 | Reset to the calibration engine; release starts calibration |
| tx_pma_rst | output | 1 | TX analog reset |
| tx_pcs_rst | output | 1 | TX digital reset |
| rx_pma_rst | output | 1 | RX analog reset |
| rx_pcs_rst | output | 1 | RX digital reset |
| tx_link_ok | output | 1 | TX path ready to send |
| rx_link_ok | output | 1 | RX path ready to receive |

## Verification
The hardest case to reach from the ports is the block parked by a short reset. Getting there needs a one-cycle `mgmt_rst` pulse while every lock and calibration input already looks healthy, so the only thing keeping the channel down is the failed qualification. A second hard case is lock-to-data arriving before lock-to-reference was ever seen, with calibration already done. The bench drives each of these on purpose. A behavioural reference model built from sample histories runs beside the design and is compared on every clock. Lock glitches shorter than the filter window are also driven, to show they never release the TX path.

// File: rtl/xcvr_pwrup_rst_seq.sv
`timescale 1ns/1ps
module xcvr_pwrup_rst_seq #(
  parameter int RST_MIN_CYC = 2,
  parameter int LOCK_FILT   = 8,
  parameter int RX_GUARD    = 4
) (
  input  logic clk,
  input  logic mgmt_rst,
  input  logic cal_busy,
  input  logic tx_pll_locked,
  input  logic rx_locked_ref,
  input  logic rx_locked_data,
  output logic xcvr_hold_rst,
  output logic cal_start_rst,
  output logic tx_pma_rst,
  output logic tx_pcs_rst,
  output logic rx_pma_rst,
  output logic rx_pcs_rst,
  output logic tx_link_ok,
  output logic rx_link_ok
);

  localparam int LW = $clog2(LOCK_FILT + 1);
  localparam int GW = $clog2(RX_GUARD + 1);
  localparam int NLK = 3;

  logic [NLK-1:0] lk_raw, sync1, sync2, lk_ok;
  logic [RST_MIN_CYC-1:0] rst_hist;
  logic run, hold_q, first_q, cal_done, ltr_seen;
  logic tx_dig, tx_rdy, rx_ana, rx_dig, rx_rdy;
  logic [GW-1:0] gcnt;
  logic start, tx_dig_n, rx_dig_n;

  assign lk_raw = {rx_locked_data, rx_locked_ref, tx_pll_locked};

  always_ff @(posedge clk) begin
    if (mgmt_rst) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= lk_raw;
      sync2 <= sync1;
    end
  end

  for (genvar i = 0; i < NLK; i++) begin : g_filt
    logic [LW-1:0] cnt;
    always_ff @(posedge clk) begin
      if (mgmt_rst || !sync2[i]) cnt <= '0;
      else if (cnt != LW'(LOCK_FILT)) cnt <= cnt + 1'b1;
    end
    assign lk_ok[i] = (cnt == LW'(LOCK_FILT));
  end

  always_ff @(posedge clk)
    rst_hist <= {rst_hist[RST_MIN_CYC-2:0], mgmt_rst};

  assign start    = !mgmt_rst && !run && (&rst_hist);
  assign tx_dig_n = !(cal_done && lk_ok[0]);
  assign rx_dig_n = !(ltr_seen && lk_ok[2] && !rx_ana);

  always_ff @(posedge clk) begin
    if (mgmt_rst) begin
      run      <= 1'b0;
      hold_q   <= 1'b1;
      first_q  <= 1'b0;
      cal_done <= 1'b0;
      ltr_seen <= 1'b0;
      tx_dig   <= 1'b1;
      tx_rdy   <= 1'b0;
      rx_ana   <= 1'b1;
      rx_dig   <= 1'b1;
      rx_rdy   <= 1'b0;
      gcnt     <= '0;
    end else begin
      if (start) begin
        run     <= 1'b1;
        hold_q  <= 1'b0;
        first_q <= 1'b1;
      end
      if (run) begin
        first_q <= 1'b0;
        if (!first_q && !cal_busy) cal_done <= 1'b1;
        ltr_seen <= ltr_seen | lk_ok[1];
        tx_dig   <= tx_dig_n;
        tx_rdy   <= !tx_dig_n && !tx_dig;
        rx_ana   <= !cal_done;
        rx_dig   <= rx_dig_n;
        rx_rdy   <= !rx_dig_n && !rx_dig && (gcnt >= GW'(RX_GUARD - 1));
        if (rx_dig) gcnt <= '0;
        else if (gcnt != GW'(RX_GUARD)) gcnt <= gcnt + 1'b1;
      end
    end
  end

  assign xcvr_hold_rst = hold_q;
  assign cal_start_rst = hold_q;
  assign tx_pma_rst    = hold_q;
  assign tx_pcs_rst    = tx_dig;
  assign rx_pma_rst    = rx_ana;
  assign rx_pcs_rst    = rx_dig;
  assign tx_link_ok    = tx_rdy;
  assign rx_link_ok    = rx_rdy;

  assert_start_qual_R1: assert property (@(posedge clk) disable iff (mgmt_rst)
    $fell(xcvr_hold_rst) |-> !$past(mgmt_rst) && $past(mgmt_rst, 2) && $past(mgmt_rst, 3));

  assert_cal_skip_R3: assert property (@(posedge clk) disable iff (mgmt_rst)
    $rose(cal_done) |-> !$past(first_q) && !$past(cal_busy));

  assert_tx_gate_R4: assert property (@(posedge clk) disable iff (mgmt_rst)
    $fell(tx_pcs_rst) |-> $past(cal_done) && $past(lk_ok[0]));

  assert_tx_ready_R5: assert property (@(posedge clk) disable iff (mgmt_rst)
    tx_link_ok |-> !tx_pcs_rst);

  assert_rx_order_R8: assert property (@(posedge clk) disable iff (mgmt_rst)
    $fell(rx_pcs_rst) |-> $past(ltr_seen) && !$past(rx_pma_rst));

  assert_rx_guard_R9: assert property (@(posedge clk) disable iff (mgmt_rst)
    $rose(rx_link_ok) |-> !$past(rx_pcs_rst) && !rx_pcs_rst);

  assert_rst_all_R11: assert property (@(posedge clk)
    mgmt_rst |=> xcvr_hold_rst && tx_pcs_rst && rx_pma_rst && rx_pcs_rst && !tx_link_ok && !rx_link_ok);

endmodule

// File: tb/xcvr_pwrup_rst_seq_tb.sv
`timescale 1ns/1ps
module xcvr_pwrup_rst_seq_tb;
  localparam int RST_MIN = 2;
  localparam int LF = 8;
  localparam int G = 4;

  logic clk = 1'b0;
  logic rst = 1'b1, busy = 1'b0, pll = 1'b0, ltr = 1'b0, ltd = 1'b0;
  logic hold, calr, txa, txd, rxa, rxd, txok, rxok;
  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  xcvr_pwrup_rst_seq #(.RST_MIN_CYC(RST_MIN), .LOCK_FILT(LF), .RX_GUARD(G)) u_dut (
    .clk(clk), .mgmt_rst(rst), .cal_busy(busy), .tx_pll_locked(pll),
    .rx_locked_ref(ltr), .rx_locked_data(ltd),
    .xcvr_hold_rst(hold), .cal_start_rst(calr), .tx_pma_rst(txa),
    .tx_pcs_rst(txd), .rx_pma_rst(rxa), .rx_pcs_rst(rxd),
    .tx_link_ok(txok), .rx_link_ok(rxok));

  task automatic chk(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: sample histories and integers
  bit qp[$], ql[$], qd[$];
  int m_rh = 0, m_g = 0;
  bit live = 0;
  bit m_run, m_hold, m_first, m_cal, m_ltrs, m_txd, m_txr, m_rxa, m_rxd, m_rxr;

  function automatic bit held(input bit q[$]);
    for (int j = 2; j <= LF + 1; j++)
      if (!q[q.size() - 1 - j]) return 1'b0;
    return 1'b1;
  endfunction

  initial begin
    for (int k = 0; k < LF + 4; k++) begin
      qp.push_back(1'b0); ql.push_back(1'b0); qd.push_back(1'b0);
    end
  end

  always @(posedge clk) begin
    bit okp, okl, okd, st, txdn, rxdn;
    okp = held(qp); okl = held(ql); okd = held(qd);
    qp.push_back(rst ? 1'b0 : pll); void'(qp.pop_front());
    ql.push_back(rst ? 1'b0 : ltr); void'(ql.pop_front());
    qd.push_back(rst ? 1'b0 : ltd); void'(qd.pop_front());
    if (rst) begin
      foreach (qp[k]) begin qp[k] = 0; ql[k] = 0; qd[k] = 0; end
      m_rh++; live = 1;
      m_run = 0; m_hold = 1; m_first = 0; m_cal = 0; m_ltrs = 0;
      m_txd = 1; m_txr = 0; m_rxa = 1; m_rxd = 1; m_rxr = 0; m_g = 0;
    end else begin
      st = !m_run && (m_rh >= RST_MIN);
      m_rh = 0;
      if (m_run) begin
        txdn = !(m_cal && okp);
        rxdn = !(m_ltrs && okd && !m_rxa);
        m_txr = !txdn && !m_txd;
        m_rxr = !rxdn && !m_rxd && (m_g >= G - 1);
        if (m_rxd) m_g = 0; else if (m_g < G) m_g++;
        m_rxa = !m_cal;
        if (!m_first && !busy) m_cal = 1;
        m_ltrs = m_ltrs | okl;
        m_txd = txdn; m_rxd = rxdn;
        m_first = 0;
      end
      if (st) begin m_run = 1; m_hold = 0; m_first = 1; end
    end
  end

  always @(negedge clk) begin
    if (live && !finished) begin
      chk(hold, m_hold, "R2 hold");
      chk(calr, m_hold, "R2 cal_start");
      chk(txa,  m_hold, "R2 tx_pma");
      chk(txd,  m_txd,  "R4 tx_pcs");
      chk(txok, m_txr,  "R5 tx_link_ok");
      chk(rxa,  m_rxa,  "R7 rx_pma");
      chk(rxd,  m_rxd,  "R8 rx_pcs");
      chk(rxok, m_rxr,  "R9 rx_link_ok");
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input int n);
    rst = 1; busy = 0; pll = 0; ltr = 0; ltd = 0;
    step(n);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // clock runs while reset is held (R1)
    step(6);
    chk(hold, 1, "R11 hold in reset"); chk(txok, 0, "R11 tx_link_ok in reset");
    chk(rxok, 0, "R11 rx_link_ok in reset");

    // scenario A: normal bring-up
    rst = 0; pll = 1; ltr = 1; ltd = 0; busy = 0;
    step(1);
    chk(hold, 0, "R2 hold released"); chk(calr, 0, "R2 cal_start released");
    step(1); busy = 1;
    step(3);
    chk(rxa, 1, "R3 first low busy ignored"); chk(txd, 1, "R3 tx_pcs held during cal");
    step(5); busy = 0;
    step(10);
    chk(rxa, 0, "R7 rx_pma after cal");
    step(10);
    chk(txok, 1, "R5 tx_link_ok up");
    ltd = 1;
    step(25);
    chk(rxd, 0, "R8 rx_pcs released"); chk(rxok, 1, "R9 rx_link_ok up");

    // loss of PLL lock and lock-to-data (R10)
    pll = 0; step(6);
    chk(txok, 0, "R10 tx_link_ok dropped"); chk(txd, 1, "R10 tx_pcs reasserted");
    pll = 1; step(20);
    chk(txok, 1, "R10 tx recovered");
    ltd = 0; step(6);
    chk(rxok, 0, "R10 rx_link_ok dropped"); chk(rxd, 1, "R10 rx_pcs reasserted");
    ltd = 1; step(25);
    chk(rxok, 1, "R10 rx recovered");

    // lock glitches shorter than the filter (R6)
    pll = 0; step(6);
    for (int k = 0; k < 6; k++) begin
      pll = 1; step(LF - 2);
      pll = 0; step(3);
    end
    chk(txok, 0, "R6 short lock pulses rejected");
    pll = 1; step(LF + 6);
    chk(txok, 1, "R6 steady lock accepted");

    // scenario B: one-cycle reset pulse parks the block (R1)
    rst = 1; step(1); rst = 0;
    step(40);
    chk(hold, 1, "R1 short pulse no start"); chk(txd, 1, "R1 tx_pcs parked");
    chk(rxok, 0, "R1 rx_link_ok parked");

    // scenario D: lock-to-data before lock-to-reference (R8)
    do_reset(3);
    rst = 0; pll = 1; ltd = 1; busy = 0;
    step(40);
    chk(txok, 1, "R4 busy never high, tx up");
    chk(rxd, 1, "R8 no release without lock-to-reference");
    ltr = 1; step(LF + 12);
    chk(rxd, 0, "R8 release after lock-to-reference");
    chk(rxok, 1, "R9 rx_link_ok after guard");

    // reset while running (R11)
    rst = 1; step(1);
    chk(txok, 0, "R11 tx_link_ok cleared"); chk(rxd, 1, "R11 rx_pcs asserted");
    step(2);
    finish_run();
  end
endmodule